// File: doc/BRIEF.md
# Boot Memory Remap Controller

This block steers every bus address to exactly one memory region and holds the boot-time remap state of the chip. Straight out of any reset the map is in boot layout: the boot nonvolatile memory answers at page zero and on-chip RAM is reached through a high alias page. The boot memory is either on-chip NVM or an off-chip device behind chip select 0. Which one is chosen by a boot-select pin captured only while the external reset is held.

Software programs the external chip selects while still in boot layout. It then sets the cancel bit of the remap control register, and the normal map takes over. From then on RAM sits at page zero, on-chip NVM sits at its own page, and each external chip select answers at its programmed 1 MB page when enabled. Wait-state fields act at once in both layouts. Base and enable fields only govern decoding once the boot layout is gone. A watchdog reset brings back the boot layout and the register defaults, but keeps the captured boot choice.

The address map uses 1 MB pages, page = `bus_addr[31:20]`. Writes are registered. The region outputs are combinational from the registered state and `bus_addr`.

Top module: `boot_remap_ctrl`

## Requirements
- R1: While `ext_rst_n` is low and after it rises, `remap_active` is 1. Chip select 0 comes out of reset enabled, with base page 0 and wait value 7. Chip selects 1 to 3 come out disabled, with base page 0 and wait value 0.
- R2: In boot layout, page 0 selects on-chip NVM (`sel_nvm`) when the captured boot choice is 0. When the captured boot choice is 1, page 0 selects `cs_sel[0]` with `wait_states` equal to the chip select 0 wait field.
- R3: In boot layout, page 0x003 selects `sel_ram`. Every other page, apart from page 0, is a decode miss.
- R4: `boot_sel` is captured on every clock edge while `ext_rst_n` is low, and is ignored at all other times, including during a watchdog reset.
- R5: `wdt_rst_req` high at a clock edge sets `remap_active` and returns all chip-select fields to their R1 defaults.
- R6: A write to index 0 with data bit 0 equal to 1 clears `remap_active` from the next cycle. A write to index 0 with bit 0 equal to 0 changes nothing, so software can never re-enter boot layout.
- R7: While `remap_active` is 1, `cs_sel[3:1]` stays 0 whatever the chip-select configuration.
- R8: A write to index 1+i (i = 0..3) stores chip select i, with bit 0 = enable, bits 3:1 = wait value and bits 31:20 = base page. Base and enable have no effect on decoding until `remap_active` is 0.
- R9: A wait value written to a chip select shows on `wait_states` from the next cycle whenever that chip select is the selected region, including in boot layout.
- R10: In normal layout, page 0 selects RAM and page 0x001 selects on-chip NVM. Otherwise the lowest-numbered enabled chip select whose base page equals the address page is selected. On-chip regions take priority over chip selects.
- R11: `decode_miss` is 1 exactly when no region output is asserted. `wait_states` is 0 unless a chip select is selected.
- R12: At most one of `sel_ram`, `sel_nvm` and `cs_sel` is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_n | input | 1 | External reset, synchronous, active low |
| wdt_rst_req | input | 1 | Watchdog reset request, active high |
| boot_sel | input | 1 | Boot choice: 0 on-chip NVM, 1 off-chip via chip select 0 |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index: 0 remap control, 1..4 chip selects 0..3 |
| cfg_wdata | input | 32 | Register write data |
| bus_addr | input | 32 | Bus address to decode |
| sel_ram | output | 1 | On-chip RAM selected |
| sel_nvm | output | 1 | On-chip NVM selected |
| cs_sel | output | 4 | External chip selects |
| remap_active | output | 1 | Boot layout in force |
| wait_states | output | 3 | Wait value of the selected chip select |
| decode_miss | output | 1 | No region matches the address |

## Verification
Addresses are probed at page 0, at the RAM alias page, at the NVM page and at programmed chip-select pages, and each probe is repeated in both layouts and with both captured boot choices. The probes show whether a page is mapped by the boot rules or by the programmed ones. Chip selects 1 to 3 are set up to match probed pages while in boot layout, which separates staged base fields from live wait fields. Overlapping chip-select bases, and a chip select placed on top of RAM, expose the priority order. Toggling the boot pin outside external reset, then issuing a watchdog reset, separates the captured choice from the live pin.

// File: rtl/boot_remap_pkg.sv
// Shared widths and the chip-select configuration record.
// Assumes a 32-bit address space carved into 1 MB pages.
package boot_remap_pkg;
    localparam int NUM_CS   = 4;
    localparam int ADDR_W   = 32;
    localparam int PAGE_LSB = 20;
    localparam int PAGE_W   = ADDR_W - PAGE_LSB;
    localparam int WAIT_W   = 3;
    localparam int IDX_W    = 3;
    localparam int DATA_W   = 32;

    typedef struct packed {
        logic              en;
        logic [PAGE_W-1:0] base;
        logic [WAIT_W-1:0] wst;
    } cs_cfg_t;
endpackage

// File: rtl/remap_state.sv
// Holds the captured boot choice and the remap flag.
// Assumes a synchronous active-low external reset and a one-cycle watchdog request.
module remap_state (
    input  logic clk,
    input  logic ext_rst_n,
    input  logic wdt_rst_req,
    input  logic boot_sel,
    input  logic cancel_wr,
    output logic remap_q,
    output logic boot_ext_q
);
    // Capture the boot pin only while the external reset is held.
    always_ff @(posedge clk) begin
        if (!ext_rst_n) begin
            boot_ext_q <= boot_sel;
        end
    end

    // Any reset enters boot layout; a cancel write leaves it.
    always_ff @(posedge clk) begin
        if (!ext_rst_n || wdt_rst_req) begin
            remap_q <= 1'b1;
        end else if (cancel_wr) begin
            remap_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cs_cfg_regs.sv
// Chip-select configuration registers, one record per chip select.
// Assumes the caller combines every reset source into rst_n.
module cs_cfg_regs
    import boot_remap_pkg::*;
#(
    parameter int N_CS = NUM_CS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    output cs_cfg_t [N_CS-1:0]       cfg_q
);
    localparam logic [WAIT_W-1:0] WAIT_MAX = '1;

    for (genvar i = 0; i < N_CS; i++) begin : g_cs
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i + 1);
        localparam cs_cfg_t RST_VAL = (i == 0) ?
            cs_cfg_t'{en: 1'b1, base: '0, wst: WAIT_MAX} :
            cs_cfg_t'{en: 1'b0, base: '0, wst: '0};

        // Load one chip-select record from its write index.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[i] <= RST_VAL;
            end else if (wr_en && wr_idx == MY_IDX) begin
                cfg_q[i].en   <= wr_data[0];
                cfg_q[i].wst  <= wr_data[WAIT_W:1];
                cfg_q[i].base <= wr_data[ADDR_W-1:PAGE_LSB];
            end
        end
    end
endmodule

// File: rtl/addr_decoder.sv
// Maps an address page to one region under the boot or normal layout.
// Assumes on-chip regions outrank chip selects and lower chip selects outrank higher.
module addr_decoder
    import boot_remap_pkg::*;
#(
    parameter int                N_CS           = NUM_CS,
    parameter logic [PAGE_W-1:0] RAM_ALIAS_PAGE = PAGE_W'(3),
    parameter logic [PAGE_W-1:0] NVM_PAGE       = PAGE_W'(1)
) (
    input  logic [PAGE_W-1:0]   page,
    input  logic                remap,
    input  logic                boot_ext,
    input  cs_cfg_t [N_CS-1:0]  cfg,
    output logic                sel_ram,
    output logic                sel_nvm,
    output logic [N_CS-1:0]     cs_sel,
    output logic [WAIT_W-1:0]   wait_o,
    output logic                miss
);
    logic [N_CS-1:0] cs_hit;
    logic            zero_page;

    assign zero_page = (page == '0);

    // Raw match per chip select; only chip select 0 may hit in boot layout.
    for (genvar i = 0; i < N_CS; i++) begin : g_hit
        if (i == 0) begin : g_cs0
            assign cs_hit[i] = remap ? (boot_ext && zero_page)
                                     : (cfg[i].en && cfg[i].base == page);
        end else begin : g_csn
            assign cs_hit[i] = !remap && cfg[i].en && cfg[i].base == page;
        end
    end

    // On-chip regions per layout.
    always_comb begin
        sel_ram = remap ? (page == RAM_ALIAS_PAGE) : zero_page;
        sel_nvm = remap ? (!boot_ext && zero_page) : (page == NVM_PAGE);
    end

    // Priority pick of one chip select and its live wait value.
    always_comb begin
        logic taken;
        taken  = sel_ram || sel_nvm;
        cs_sel = '0;
        wait_o = '0;
        for (int i = 0; i < N_CS; i++) begin
            if (cs_hit[i] && !taken) begin
                cs_sel[i] = 1'b1;
                wait_o    = cfg[i].wst;
                taken     = 1'b1;
            end
        end
        miss = !taken;
    end
endmodule

// File: rtl/boot_remap_ctrl.sv
// Top: remap state, chip-select registers and address decoding.
// Assumes writes and reset are synchronous; region outputs follow bus_addr combinationally.
module boot_remap_ctrl
    import boot_remap_pkg::*;
#(
    parameter logic [PAGE_W-1:0] RAM_ALIAS_PAGE = PAGE_W'(3),
    parameter logic [PAGE_W-1:0] NVM_PAGE       = PAGE_W'(1)
) (
    input  logic                 clk,
    input  logic                 ext_rst_n,
    input  logic                 wdt_rst_req,
    input  logic                 boot_sel,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [DATA_W-1:0]    cfg_wdata,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic                 sel_ram,
    output logic                 sel_nvm,
    output logic [NUM_CS-1:0]    cs_sel,
    output logic                 remap_active,
    output logic [WAIT_W-1:0]    wait_states,
    output logic                 decode_miss
);
    logic              cancel_wr;
    logic              rst_all_n;
    logic              boot_ext;
    cs_cfg_t [NUM_CS-1:0] cfg;

    // Only a 1 in the cancel bit of index 0 leaves boot layout.
    assign cancel_wr = cfg_we && (cfg_idx == '0) && cfg_wdata[0];
    // Configuration restarts on either reset source.
    assign rst_all_n = ext_rst_n && !wdt_rst_req;

    remap_state u_state (
        .clk         (clk),
        .ext_rst_n   (ext_rst_n),
        .wdt_rst_req (wdt_rst_req),
        .boot_sel    (boot_sel),
        .cancel_wr   (cancel_wr),
        .remap_q     (remap_active),
        .boot_ext_q  (boot_ext)
    );

    cs_cfg_regs #(.N_CS(NUM_CS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_all_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_data (cfg_wdata),
        .cfg_q   (cfg)
    );

    addr_decoder #(
        .N_CS           (NUM_CS),
        .RAM_ALIAS_PAGE (RAM_ALIAS_PAGE),
        .NVM_PAGE       (NVM_PAGE)
    ) u_dec (
        .page     (bus_addr[ADDR_W-1:PAGE_LSB]),
        .remap    (remap_active),
        .boot_ext (boot_ext),
        .cfg      (cfg),
        .sel_ram  (sel_ram),
        .sel_nvm  (sel_nvm),
        .cs_sel   (cs_sel),
        .wait_o   (wait_states),
        .miss     (decode_miss)
    );
endmodule

// File: rtl/boot_remap_chk.sv
// Temporal checks on the controller's ports, attached by bind.
module boot_remap_chk
    import boot_remap_pkg::*;
#(
    parameter logic [PAGE_W-1:0] RAM_ALIAS_PAGE = PAGE_W'(3)
) (
    input logic                 clk,
    input logic                 ext_rst_n,
    input logic                 wdt_rst_req,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 sel_ram,
    input logic                 sel_nvm,
    input logic [NUM_CS-1:0]    cs_sel,
    input logic                 remap_active,
    input logic [WAIT_W-1:0]    wait_states,
    input logic                 decode_miss
);
    logic [PAGE_W-1:0] page;
    assign page = bus_addr[ADDR_W-1:PAGE_LSB];

    a_r12_one_region: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $onehot0({sel_ram, sel_nvm, cs_sel}));

    a_r7_boot_cs0_only: assert property (@(posedge clk) disable iff (!ext_rst_n)
        remap_active |-> (cs_sel[NUM_CS-1:1] == '0));

    a_r3_alias_is_ram: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (remap_active && page == RAM_ALIAS_PAGE) |-> sel_ram);

    a_r2_boot_zero_mapped: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (remap_active && page == '0) |-> ((sel_nvm || cs_sel[0]) && !decode_miss));

    a_r6_no_sw_reentry: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $rose(remap_active) |-> $past(wdt_rst_req));

    a_r10_ram_at_zero: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (!remap_active && page == '0) |-> sel_ram);

    a_r11_wait_idle: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (cs_sel == '0) |-> (wait_states == '0));
endmodule

bind boot_remap_ctrl boot_remap_chk #(.RAM_ALIAS_PAGE(RAM_ALIAS_PAGE)) u_chk (
    .clk          (clk),
    .ext_rst_n    (ext_rst_n),
    .wdt_rst_req  (wdt_rst_req),
    .bus_addr     (bus_addr),
    .sel_ram      (sel_ram),
    .sel_nvm      (sel_nvm),
    .cs_sel       (cs_sel),
    .remap_active (remap_active),
    .wait_states  (wait_states),
    .decode_miss  (decode_miss)
);

// File: tb/boot_remap_ctrl_tb.sv
// Scoreboard bench: the driver queues expected results, the monitor compares them.
module boot_remap_ctrl_tb;
    logic        clk = 1'b0;
    logic        ext_rst_n = 1'b0;
    logic        wdt_rst_req = 1'b0;
    logic        boot_sel = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] bus_addr = '0;
    logic        sel_ram, sel_nvm, remap_active, decode_miss;
    logic [3:0]  cs_sel;
    logic [2:0]  wait_states;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic [5:0] sel;   // {cs_sel[3:0], sel_nvm, sel_ram}
        logic       miss;
        logic [2:0] wst;
        logic       remap;
        string      tag;
    } exp_t;

    exp_t q[$];
    event probe_ev;

    // Reference state kept from the requirements.
    logic       m_remap, m_boot;
    logic       m_en[4];
    logic [11:0] m_base[4];
    logic [2:0] m_wst[4];

    always #5 clk = ~clk;

    boot_remap_ctrl u_dut (
        .clk(clk), .ext_rst_n(ext_rst_n), .wdt_rst_req(wdt_rst_req),
        .boot_sel(boot_sel), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .bus_addr(bus_addr), .sel_ram(sel_ram),
        .sel_nvm(sel_nvm), .cs_sel(cs_sel), .remap_active(remap_active),
        .wait_states(wait_states), .decode_miss(decode_miss)
    );

    task automatic model_defaults();
        m_remap = 1'b1;
        for (int i = 0; i < 4; i++) begin
            m_en[i] = (i == 0); m_base[i] = '0; m_wst[i] = (i == 0) ? 3'd7 : 3'd0;
        end
    endtask

    function automatic exp_t predict(input logic [31:0] a, input string tag);
        exp_t e;
        logic [11:0] pg;
        logic done;
        pg = a[31:20];
        e.sel = '0; e.wst = '0; e.remap = m_remap; e.tag = tag; done = 1'b0;
        if (m_remap) begin
            if (pg == 12'h003) begin e.sel[0] = 1'b1; done = 1'b1; end
            else if (pg == 12'h000 && !m_boot) begin e.sel[1] = 1'b1; done = 1'b1; end
            else if (pg == 12'h000 && m_boot) begin e.sel[2] = 1'b1; e.wst = m_wst[0]; done = 1'b1; end
        end else begin
            if (pg == 12'h000) begin e.sel[0] = 1'b1; done = 1'b1; end
            else if (pg == 12'h001) begin e.sel[1] = 1'b1; done = 1'b1; end
            for (int i = 0; i < 4; i++) begin
                if (!done && m_en[i] && m_base[i] == pg) begin
                    e.sel[2+i] = 1'b1; e.wst = m_wst[i]; done = 1'b1;
                end
            end
        end
        e.miss = !done;
        return e;
    endfunction

    task automatic ext_reset(input logic pin);
        @(negedge clk);
        ext_rst_n = 1'b0; boot_sel = pin;
        repeat (3) @(negedge clk);
        ext_rst_n = 1'b1;
        m_boot = pin; model_defaults();
    endtask

    task automatic wdt_reset();
        @(negedge clk);
        wdt_rst_req = 1'b1;
        @(negedge clk);
        wdt_rst_req = 1'b0;
        model_defaults();
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx == 3'd0 && d[0]) m_remap = 1'b0;
        if (idx >= 3'd1 && idx <= 3'd4) begin
            m_en[idx-1] = d[0]; m_wst[idx-1] = d[3:1]; m_base[idx-1] = d[31:20];
        end
    endtask

    function automatic logic [31:0] csw(input logic [11:0] base, input logic [2:0] w, input logic en);
        return {base, 16'h0, w, en};
    endfunction

    // Driver: apply an address and queue what the requirements predict.
    task automatic probe(input logic [31:0] a, input string tag);
        @(negedge clk);
        bus_addr = a;
        q.push_back(predict(a, tag));
        ->probe_ev;
    endtask

    // Monitor: compare each queued expectation against the ports.
    initial begin
        forever begin
            @(probe_ev);
            #1;
            if (q.size() != 0) begin
                exp_t e;
                logic [5:0] got;
                e = q.pop_front();
                got = {cs_sel, sel_nvm, sel_ram};
                checks++;
                if (got !== e.sel || decode_miss !== e.miss ||
                    wait_states !== e.wst || remap_active !== e.remap) begin
                    errors++;
                    $display("FAIL %s: got sel=%b miss=%b wait=%0d remap=%b, exp sel=%b miss=%b wait=%0d remap=%b",
                             e.tag, got, decode_miss, wait_states, remap_active,
                             e.sel, e.miss, e.wst, e.remap);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: got hung run, exp completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_boot = 1'b0; model_defaults();
        // R1: remap held during reset
        @(negedge clk); @(negedge clk);
        checks++;
        if (remap_active !== 1'b1) begin
            errors++; $display("FAIL R1 in reset: got remap=%b exp 1", remap_active);
        end
        ext_reset(1'b0);
        probe(32'h0000_0100, "R1 R2 on-chip boot page 0");
        probe(32'h0030_0040, "R3 RAM alias");
        probe(32'h0010_0000, "R3 miss at NVM page in boot layout");
        probe(32'h7FF0_0000, "R11 unmapped miss");
        // R7 R8: chip select 1 configured but not effective in boot layout
        wr(3'd2, csw(12'h400, 3'd2, 1'b1));
        probe(32'h4000_0000, "R7 R8 cs1 staged in boot layout");
        wr(3'd0, 32'h0);
        probe(32'h0000_0000, "R6 zero write ignored");
        wr(3'd0, 32'h1);
        probe(32'h0000_0000, "R6 R10 RAM at zero after cancel");
        probe(32'h0010_0004, "R10 NVM page");
        probe(32'h4000_0008, "R8 R9 cs1 after cancel");
        probe(32'h0030_0000, "R11 alias gone after cancel");
        wr(3'd0, 32'h0);
        probe(32'h0000_0000, "R6 no reentry");
        // R4 R5: pin moves outside reset, watchdog keeps capture
        @(negedge clk); boot_sel = 1'b1;
        wdt_reset();
        probe(32'h0000_0000, "R4 R5 boot choice kept after watchdog");
        wr(3'd0, 32'h1);
        probe(32'h4000_0000, "R5 cs1 config cleared by watchdog");
        // Off-chip boot
        ext_reset(1'b1);
        probe(32'h0000_0010, "R1 R2 off-chip boot cs0 wait 7");
        wr(3'd1, csw(12'h000, 3'd3, 1'b1));
        probe(32'h0000_0010, "R9 cs0 wait immediate in boot layout");
        wr(3'd3, csw(12'h000, 3'd5, 1'b1));
        probe(32'h0000_0000, "R7 cs2 blocked in boot layout");
        wr(3'd1, csw(12'h200, 3'd4, 1'b1));
        wr(3'd3, csw(12'h200, 3'd5, 1'b1));
        wr(3'd4, csw(12'h500, 3'd6, 1'b1));
        wr(3'd2, csw(12'h500, 3'd1, 1'b0));
        probe(32'h2000_0000, "R8 base staged, cs0 still page 0");
        wr(3'd0, 32'hFFFF_FFFF);
        probe(32'h2000_0000, "R10 cs0 beats cs2");
        probe(32'h5000_0000, "R8 R10 disabled cs1 skipped, cs3");
        probe(32'h0000_0000, "R10 RAM beats cs");
        wr(3'd4, csw(12'h000, 3'd2, 1'b1));
        probe(32'h0000_0000, "R10 R12 cs3 at page 0 loses to RAM");
        @(negedge clk); boot_sel = 1'b0;
        wdt_reset();
        probe(32'h0000_0000, "R4 off-chip choice kept");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule